// File: doc/BRIEF.md
# Interrupt Vector Receive Unit

This block keeps the pending-interrupt vector for one hardware thread and exposes it as three memory-mapped registers. A receive register reads back the whole vector, and writing it acknowledges interrupts in bulk: every bit set in the write data is cleared. A dispatch register can only be read. Each read returns the number of the highest pending interrupt and retires that interrupt. A post register can only be written. Each write sends one interrupt number to another thread through a valid/thread/number output port. Interrupts from other threads arrive on a one-cycle input strobe and set their bit at the next clock edge.

Only hyperprivileged code may use these registers. Any other access is refused with a fault code and has no effect. A small state machine produces the response. It moves to Acknowledge when a request is permitted, to Fault when a request is refused, and to Idle when no request is present. Each of these transitions can start from any of the three states. The response appears in the cycle after the request, and a new request may be issued in every cycle.

Top module: `intr_receive_unit`

## Requirements
- R1: After reset the pending vector is all zero, and `rsp_valid` and `post_valid` are low.
- R2: A request is answered exactly one cycle later with `rsp_valid` high. A read of the receive register (`req_sel`=0) returns the whole pending vector as it stood when the request was sampled.
- R3: A write to the receive register clears every pending bit that is 1 in `req_wdata` and leaves all other bits unchanged. Its response data is zero.
- R4: A read of the dispatch register (`req_sel`=1) returns the index of the most significant pending bit, zero-extended, and clears that bit.
- R5: A dispatch read with an empty vector returns zero and leaves the vector unchanged.
- R6: A write to the post register (`req_sel`=2) raises `post_valid` for one cycle in the response cycle, with `post_num` = `req_wdata[5:0]` and `post_thread` = `req_wdata[12:8]`. The pending vector is unchanged.
- R7: A read of the post register or a write to the dispatch register is refused with `rsp_fault`=1 (data-access fault). Read data is zero, no post is sent, and the vector is unchanged.
- R8: A request with `req_hpriv` low is refused with `rsp_fault`=1 when `req_priv` is high and with `rsp_fault`=2 (privileged-action fault) when `req_priv` is low. It has no effect. A permitted request answers with `rsp_fault`=0.
- R9: `in_valid` with `in_num` sets that pending bit at the next edge. If the same bit is cleared in the same cycle by a receive write or a dispatch read, the bit ends up set.
- R10: Selector value 3 names no register and is refused with `rsp_fault`=1 and no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 receive, 1 dispatch, 2 post, 3 reserved |
| req_hpriv | input | 1 | Requester is hyperprivileged |
| req_priv | input | 1 | Requester is privileged |
| req_wdata | input | 64 | Write data |
| in_valid | input | 1 | Incoming interrupt strobe |
| in_num | input | 6 | Incoming interrupt number |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_fault | output | 2 | 0 none, 1 data-access fault, 2 privileged-action fault |
| rsp_rdata | output | 64 | Read data, zero for writes and faults |
| post_valid | output | 1 | Outgoing interrupt post |
| post_thread | output | 5 | Target thread of the post |
| post_num | output | 6 | Interrupt number of the post |

## Verification
Two functions can act on the same bit in one cycle: an incoming interrupt can set a bit while a receive write or a dispatch read clears it. The bench provokes this on purpose. Directed cases strobe `in_num` at exactly the bit being cleared, or at the bit that a dispatch is about to retire. Random traffic repeats the collision many times, because the strobe fires in about half of all cycles. A bench model applies the clear first and the set second, so the set wins. Later receive reads and the returned dispatch indices must match that model.

// File: rtl/intr_rx_pkg.sv
package intr_rx_pkg;

    typedef enum logic [1:0] {
        SEL_RECV = 2'd0,
        SEL_DISP = 2'd1,
        SEL_POST = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DATA = 2'd1,
        FLT_PRIV = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/intr_msb_find.sv
module intr_msb_find #(
    parameter int VEC_W = 64,
    parameter int IDX_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < VEC_W; i++) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intr_vec_store.sv
module intr_vec_store #(
    parameter int VEC_W = 64,
    parameter int IDX_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             bulk_clr_en,
    input  logic [VEC_W-1:0] bulk_clr_mask,
    input  logic             disp_en,
    output logic [VEC_W-1:0] vec_q,
    output logic [IDX_W-1:0] top_idx,
    output logic             top_found
);

    logic [VEC_W-1:0] clr_mask;
    logic [VEC_W-1:0] set_mask;

    intr_msb_find #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_find (
        .vec   (vec_q),
        .idx   (top_idx),
        .found (top_found)
    );

    always_comb begin
        clr_mask = '0;
        if (bulk_clr_en) begin
            clr_mask = bulk_clr_mask;
        end else if (disp_en && top_found) begin
            clr_mask[top_idx] = 1'b1;
        end
        set_mask = '0;
        if (set_en) begin
            set_mask[set_idx] = 1'b1;
        end
    end

    // The clear is applied first and the set second, so a set wins over a clear of the same bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            vec_q <= (vec_q & ~clr_mask) | set_mask;
        end
    end

    p_set_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> vec_q[$past(set_idx)]);

    p_bulk_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_clr_en && !set_en) |=> ((vec_q & $past(bulk_clr_mask)) == '0));

    p_disp_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && top_found && !(set_en && set_idx == top_idx)) |=> !vec_q[$past(top_idx)]);

    p_disp_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !top_found && !set_en) |=> (vec_q == '0));

endmodule

// File: rtl/intr_access_ctrl.sv
module intr_access_ctrl
    import intr_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_sel,
    input  logic       req_hpriv,
    input  logic       req_priv,
    output logic       do_recv_rd,
    output logic       do_recv_wr,
    output logic       do_disp,
    output logic       do_post,
    output logic       rsp_valid,
    output logic [1:0] rsp_fault
);

    rsp_state_e state_q, state_d;
    fault_e     code_q, code_d;
    fault_e     req_code;
    reg_sel_e   sel;
    logic       permitted;

    assign sel = reg_sel_e'(req_sel);

    always_comb begin
        req_code = FLT_NONE;
        if (!req_hpriv) begin
            req_code = req_priv ? FLT_DATA : FLT_PRIV;
        end else begin
            unique case (sel)
                SEL_RECV: req_code = FLT_NONE;
                SEL_DISP: req_code = req_write ? FLT_DATA : FLT_NONE;
                SEL_POST: req_code = req_write ? FLT_NONE : FLT_DATA;
                SEL_RSVD: req_code = FLT_DATA;
            endcase
        end
        permitted  = req_valid && (req_code == FLT_NONE);
        do_recv_rd = permitted && (sel == SEL_RECV) && !req_write;
        do_recv_wr = permitted && (sel == SEL_RECV) && req_write;
        do_disp    = permitted && (sel == SEL_DISP);
        do_post    = permitted && (sel == SEL_POST);
    end

    // Every state takes the same exits: Acknowledge on a permitted request,
    // Fault on a refused one, Idle with no request.
    always_comb begin
        state_d = ST_IDLE;
        code_d  = FLT_NONE;
        unique case (state_q)
            ST_IDLE, ST_ACK, ST_FAULT: begin
                if (!req_valid) begin
                    state_d = ST_IDLE;
                end else if (permitted) begin
                    state_d = ST_ACK;
                end else begin
                    state_d = ST_FAULT;
                    code_d  = req_code;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= FLT_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        rsp_valid = (state_q != ST_IDLE);
        rsp_fault = (state_q == ST_FAULT) ? code_q : FLT_NONE;
    end

    p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_nonhyp_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hpriv) |=> (rsp_fault != 2'd0));

    p_priv_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hpriv && req_priv) |=> (rsp_fault == 2'd1));

    p_rsvd_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel == 2'd3) |=> (rsp_fault != 2'd0));

endmodule

// File: rtl/intr_receive_unit.sv
module intr_receive_unit #(
    parameter int VEC_W      = 64,
    parameter int THREAD_W   = 5,
    parameter int THREAD_LSB = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [1:0]                 req_sel,
    input  logic                       req_hpriv,
    input  logic                       req_priv,
    input  logic [VEC_W-1:0]           req_wdata,
    input  logic                       in_valid,
    input  logic [$clog2(VEC_W)-1:0]   in_num,
    output logic                       rsp_valid,
    output logic [1:0]                 rsp_fault,
    output logic [VEC_W-1:0]           rsp_rdata,
    output logic                       post_valid,
    output logic [THREAD_W-1:0]        post_thread,
    output logic [$clog2(VEC_W)-1:0]   post_num
);

    localparam int IDX_W = $clog2(VEC_W);

    logic             do_recv_rd, do_recv_wr, do_disp, do_post;
    logic [VEC_W-1:0] vec_q;
    logic [IDX_W-1:0] top_idx;
    logic             top_found;

    intr_access_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_sel    (req_sel),
        .req_hpriv  (req_hpriv),
        .req_priv   (req_priv),
        .do_recv_rd (do_recv_rd),
        .do_recv_wr (do_recv_wr),
        .do_disp    (do_disp),
        .do_post    (do_post),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault)
    );

    intr_vec_store #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en        (in_valid),
        .set_idx       (in_num),
        .bulk_clr_en   (do_recv_wr),
        .bulk_clr_mask (req_wdata),
        .disp_en       (do_disp),
        .vec_q         (vec_q),
        .top_idx       (top_idx),
        .top_found     (top_found)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata   <= '0;
            post_valid  <= 1'b0;
            post_thread <= '0;
            post_num    <= '0;
        end else begin
            if (do_recv_rd) begin
                rsp_rdata <= vec_q;
            end else if (do_disp && top_found) begin
                rsp_rdata <= {{(VEC_W-IDX_W){1'b0}}, top_idx};
            end else begin
                rsp_rdata <= '0;
            end
            post_valid <= do_post;
            if (do_post) begin
                post_num    <= req_wdata[IDX_W-1:0];
                post_thread <= req_wdata[THREAD_LSB +: THREAD_W];
            end
        end
    end

    p_post_sent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hpriv && req_write && req_sel == 2'd2) |=> post_valid);

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> (!post_valid && rsp_rdata == '0));

    p_post_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !post_valid);

endmodule

// File: tb/sim_intr_receive_unit.sv
module sim_intr_receive_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_hpriv = 1'b0, req_priv = 1'b0;
    logic [1:0]  req_sel = 2'd0;
    logic [63:0] req_wdata = '0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_num = '0;
    logic        rsp_valid, post_valid;
    logic [1:0]  rsp_fault;
    logic [63:0] rsp_rdata;
    logic [4:0]  post_thread;
    logic [5:0]  post_num;

    int total = 0;
    int bad = 0;
    logic [63:0] mvec = '0;

    always #(CLK_P/2) clk = ~clk;

    intr_receive_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_hpriv(req_hpriv), .req_priv(req_priv),
        .req_wdata(req_wdata), .in_valid(in_valid), .in_num(in_num),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .post_valid(post_valid), .post_thread(post_thread), .post_num(post_num)
    );

    function automatic int msb_of(input logic [63:0] v);
        int r = -1;
        for (int i = 0; i < 64; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [1:0] exp_fault(input logic [1:0] sel, input logic wr,
                                             input logic hp, input logic pr);
        if (!hp) return pr ? 2'd1 : 2'd2;
        if (sel == 2'd3) return 2'd1;
        if (sel == 2'd1 && wr) return 2'd1;
        if (sel == 2'd2 && !wr) return 2'd1;
        return 2'd0;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic v, input logic [1:0] sel, input logic wr, input logic hp,
                      input logic pr, input logic [63:0] wd, input logic iv,
                      input logic [5:0] inum, input string tag);
        logic [1:0]  ef;
        logic [63:0] erd;
        logic        ok;
        int          m;
        req_valid = v; req_sel = sel; req_write = wr; req_hpriv = hp; req_priv = pr;
        req_wdata = wd; in_valid = iv; in_num = inum;
        ef  = exp_fault(sel, wr, hp, pr);
        ok  = v && (ef == 2'd0);
        m   = msb_of(mvec);
        erd = '0;
        if (ok && sel == 2'd0 && !wr) erd = mvec;
        if (ok && sel == 2'd1 && m >= 0) erd = 64'(m);
        @(negedge clk);
        chk(64'(rsp_valid), 64'(v), {tag, " rsp_valid"});
        if (v) begin
            chk(64'(rsp_fault), 64'(ef), {tag, " fault"});
            chk(rsp_rdata, erd, {tag, " rdata"});
        end
        chk(64'(post_valid), 64'(ok && sel == 2'd2), {tag, " post_valid"});
        if (ok && sel == 2'd2) begin
            chk(64'(post_num), 64'(wd[5:0]), {tag, " post_num"});
            chk(64'(post_thread), 64'(wd[12:8]), {tag, " post_thread"});
        end
        if (ok && sel == 2'd0 && wr) mvec = mvec & ~wd;
        if (ok && sel == 2'd1 && m >= 0) mvec[m] = 1'b0;
        if (iv) mvec[inum] = 1'b1;
        req_valid = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(64'(rsp_valid), 64'd0, "R1 rsp_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(64'(post_valid), 64'd0, "R1 post_valid after reset");
        op(1, 2'd0, 0, 1, 1, '0, 0, 6'd0, "R1 vector zero");
        op(0, 2'd0, 0, 1, 1, '0, 1, 6'd3, "R9 set bit 3");
        op(0, 2'd0, 0, 1, 1, '0, 1, 6'd63, "R9 set bit 63");
        op(1, 2'd0, 0, 1, 1, '0, 1, 6'd0, "R2 read while set bit 0");
        op(1, 2'd0, 0, 1, 1, '0, 0, 6'd0, "R2 read full");
        op(1, 2'd0, 1, 1, 1, 64'h8, 0, 6'd0, "R3 clear bit 3");
        op(1, 2'd0, 0, 1, 1, '0, 0, 6'd0, "R3 readback");
        op(1, 2'd1, 0, 1, 1, '0, 0, 6'd0, "R4 dispatch 63");
        op(1, 2'd1, 0, 1, 1, '0, 0, 6'd0, "R4 dispatch 0");
        op(1, 2'd1, 0, 1, 1, '0, 0, 6'd0, "R5 dispatch empty");
        op(1, 2'd0, 0, 1, 1, '0, 0, 6'd0, "R5 still empty");
        op(1, 2'd2, 1, 1, 0, 64'h0000_1F2A, 0, 6'd0, "R6 post");
        op(1, 2'd0, 0, 1, 1, '0, 1, 6'd5, "R6 vector unchanged by post");
        op(1, 2'd2, 0, 1, 1, '0, 0, 6'd0, "R7 read post reg");
        op(1, 2'd1, 1, 1, 1, '0, 0, 6'd0, "R7 write dispatch reg");
        op(1, 2'd3, 0, 1, 1, '0, 0, 6'd0, "R10 reserved read");
        op(1, 2'd3, 1, 1, 1, '1, 0, 6'd0, "R10 reserved write");
        op(1, 2'd0, 1, 0, 1, '1, 0, 6'd0, "R8 priv non-hyper write");
        op(1, 2'd1, 0, 0, 0, '0, 0, 6'd0, "R8 user dispatch");
        op(1, 2'd0, 0, 1, 1, '0, 0, 6'd0, "R8 R7 no effect readback");
        op(1, 2'd0, 1, 1, 1, 64'h20, 1, 6'd5, "R9 set beats bulk clear");
        op(1, 2'd1, 0, 1, 1, '0, 1, 6'd5, "R9 set beats dispatch clear");
        op(1, 2'd0, 0, 1, 1, '0, 0, 6'd0, "R9 readback");
        for (int n = 0; n < 600; n++) begin
            logic [1:0]  s;
            logic        w;
            logic [63:0] d;
            string       t;
            s = 2'($urandom % 4);
            w = 1'($urandom);
            d = {$urandom, $urandom} & {$urandom, $urandom};
            case (s)
                2'd0: t = w ? "R3 random" : "R2 random";
                2'd1: t = "R4 random";
                2'd2: t = "R6 random";
                default: t = "R10 random";
            endcase
            op(1'($urandom % 4 != 0), s, w, 1'($urandom % 8 != 0), 1'($urandom),
               d, 1'($urandom), 6'($urandom), t);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule